// File: doc/BRIEF.md
# Banked Indirect Register Front End

This block is the host-side register front end for a card controller with up to four sockets. The host sees only a two-byte aperture. Offset 0 holds an index latch, and offset 1 is a data window onto whatever 8-bit register the latched index selects. The top bits of the index pick a socket and the low six bits pick a register inside that socket's bank, so the banks sit at a fixed stride of 0x40 index steps.

A two-bit configuration strap sets how many sockets exist. A socket outside that count behaves as absent: it reads as zero and ignores writes. The block also derives a per-socket card-present flag from bits 3 and 2 of register 1 in each bank. The host bus is a plain synchronous byte bus. A read is taken at a clock edge, and its data is returned with a valid strobe in the following cycle.

Top module: `sockreg_front`

## Requirements
- R1: After synchronous reset, the index latch and every register of every socket read as 0x00, `card_present` is all zero, and `host_rvalid` is low.
- R2: A write with `host_addr`=0 loads `host_wdata` into the index latch. A read with `host_addr`=0 returns the current latch value.
- R3: Every accepted read raises `host_rvalid` for exactly the next cycle, with `host_rdata` valid in that cycle. A read or write with `host_addr`=1 accesses the register selected by the latched index.
- R4: Index bits 7:6 select the socket and bits 5:0 select the register, so socket n's register k sits at index k + n*0x40. Equal register numbers in different sockets are separate storage.
- R5: `sock_count` follows the strap one cycle later: 00 gives 2, 01 gives 1, and 10 or 11 give 4.
- R6: An index whose socket number is at or above `sock_count` reads as 0x00 through offset 1, and writes to it change nothing. Such writes stay lost after the count is later raised.
- R7: A 16-bit value kept as a low byte at index k and a high byte at index k+1 retains both bytes independently.
- R8: `card_present[n]` is 1 only when socket n is below `sock_count` and its register 1 has bits 3 and 2 both set. The flag updates in the cycle after the write.
- R9: A read-modify-write (select the index, read, select the index again, write) changes only the target register. Its neighbours keep their values.
- R10: When `host_rd` and `host_wr` are high in the same cycle, only the write takes effect, and no read data is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 1 | Aperture offset: 0 = index, 1 = data |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid with `host_rvalid` |
| host_rvalid | output | 1 | High the cycle after an accepted read |
| cfg_strap | input | 2 | Socket-count strap |
| sock_count | output | 3 | Number of active sockets |
| card_present | output | 4 | Per-socket card-present flags |

## Verification
The hardest case to reach is a write that was dropped because its socket was inactive. That write is invisible while the socket stays inactive, since reads also return zero then. The stimulus writes to socket 1 while the strap allows one socket, then moves the strap to four sockets and reads the same index, expecting zero. A mid-run reset is also exercised. It must empty registers already holding data, even though the register storage itself is never swept.

// File: rtl/sockreg_pkg.sv
package sockreg_pkg;
  typedef enum logic {AP_INDEX = 1'b0, AP_DATA = 1'b1} aperture_e;

  // strap decode: 00 -> 2, 01 -> 1, 1x -> 4, then clamped to the build limit
  function automatic int unsigned strap_to_count(input logic [1:0] strap, input int unsigned max_sock);
    int unsigned c;
    case (strap)
      2'b00:   c = 2;
      2'b01:   c = 1;
      default: c = 4;
    endcase
    if (c > max_sock) c = max_sock;
    return c;
  endfunction
endpackage

// File: rtl/sockreg_strap.sv
module sockreg_strap #(
  parameter int NUM_SOCK = 4,
  parameter int CNT_W    = $clog2(NUM_SOCK + 1)
) (
  input  logic                clk,
  input  logic [1:0]          strap,
  output logic [CNT_W-1:0]    count_q,
  output logic [NUM_SOCK-1:0] active_q
);
  import sockreg_pkg::*;
  logic [CNT_W-1:0]    count_d;
  logic [NUM_SOCK-1:0] active_d;

  always_comb begin
    count_d = CNT_W'(strap_to_count(strap, NUM_SOCK));
    for (int i = 0; i < NUM_SOCK; i++) active_d[i] = (CNT_W'(i) < count_d);
  end

  // the strap is a static level, so it is followed even during reset
  always_ff @(posedge clk) begin
    count_q  <= count_d;
    active_q <= active_d;
  end
endmodule

// File: rtl/sockreg_index.sv
module sockreg_index #(
  parameter int IDX_W  = 8,
  parameter int REG_W  = 6,
  parameter int SOCK_W = IDX_W - REG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [IDX_W-1:0]  din,
  output logic [IDX_W-1:0]  idx_q,
  output logic [SOCK_W-1:0] sock_sel,
  output logic [REG_W-1:0]  reg_sel
);
  always_ff @(posedge clk) begin
    if (rst)       idx_q <= '0;
    else if (load) idx_q <= din;
  end

  assign sock_sel = idx_q[IDX_W-1 -: SOCK_W];
  assign reg_sel  = idx_q[REG_W-1:0];
endmodule

// File: rtl/sockreg_bank.sv
module sockreg_bank #(
  parameter int DATA_W      = 8,
  parameter int REG_W       = 6,
  parameter int STATUS_REG  = 1,
  parameter logic [DATA_W-1:0] PRESENT_MASK = 8'h0C,
  parameter int DEPTH       = 1 << REG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [REG_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [REG_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata,
  output logic              present_q
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  written_q;
  logic [DATA_W-1:0] rd_q;
  logic              rd_vld_q;

  // plain array: no reset, inferable as block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rd_q <= mem[raddr];
  end

  // per-entry written flags stand in for clearing the array at reset
  always_ff @(posedge clk) begin
    if (rst) begin
      written_q <= '0;
      rd_vld_q  <= 1'b0;
      present_q <= 1'b0;
    end else begin
      if (we) written_q[waddr] <= 1'b1;
      if (re) rd_vld_q <= written_q[raddr];
      if (we && waddr == REG_W'(STATUS_REG))
        present_q <= ((wdata & PRESENT_MASK) == PRESENT_MASK);
    end
  end

  assign rdata = rd_vld_q ? rd_q : '0;
endmodule

// File: rtl/sockreg_front.sv
module sockreg_front #(
  parameter int NUM_SOCK   = 4,
  parameter int DATA_W     = 8,
  parameter int IDX_W      = 8,
  parameter int REG_W      = 6,
  parameter int STATUS_REG = 1,
  parameter int CNT_W      = $clog2(NUM_SOCK + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                host_addr,
  input  logic                host_wr,
  input  logic                host_rd,
  input  logic [DATA_W-1:0]   host_wdata,
  output logic [DATA_W-1:0]   host_rdata,
  output logic                host_rvalid,
  input  logic [1:0]          cfg_strap,
  output logic [CNT_W-1:0]    sock_count,
  output logic [NUM_SOCK-1:0] card_present
);
  import sockreg_pkg::*;
  localparam int SOCK_W = IDX_W - REG_W;

  logic [CNT_W-1:0]    count_q;
  logic [NUM_SOCK-1:0] active_q;
  logic [IDX_W-1:0]    idx_q;
  logic [SOCK_W-1:0]   sock_sel;
  logic [REG_W-1:0]    reg_sel;
  logic                idx_load, data_wr, rd_acc, sel_active;

  assign idx_load   = host_wr && (host_addr == AP_INDEX);
  assign data_wr    = host_wr && (host_addr == AP_DATA);
  assign rd_acc     = host_rd && !host_wr;
  assign sel_active = (CNT_W'(sock_sel) < count_q);

  sockreg_strap #(.NUM_SOCK(NUM_SOCK), .CNT_W(CNT_W)) u_strap (
    .clk(clk), .strap(cfg_strap), .count_q(count_q), .active_q(active_q));

  sockreg_index #(.IDX_W(IDX_W), .REG_W(REG_W), .SOCK_W(SOCK_W)) u_index (
    .clk(clk), .rst(rst), .load(idx_load), .din(IDX_W'(host_wdata)),
    .idx_q(idx_q), .sock_sel(sock_sel), .reg_sel(reg_sel));

  logic [DATA_W-1:0]   bank_rd [NUM_SOCK];
  logic [NUM_SOCK-1:0] bank_present;

  for (genvar n = 0; n < NUM_SOCK; n++) begin : g_bank
    logic hit;
    assign hit = (sock_sel == SOCK_W'(n));
    sockreg_bank #(.DATA_W(DATA_W), .REG_W(REG_W), .STATUS_REG(STATUS_REG)) u_bank (
      .clk(clk), .rst(rst),
      .we(data_wr && sel_active && hit), .waddr(reg_sel), .wdata(host_wdata),
      .re(rd_acc && (host_addr == AP_DATA) && hit), .raddr(reg_sel),
      .rdata(bank_rd[n]), .present_q(bank_present[n]));
  end

  // read return path
  logic              rvalid_q, rd_idx_q, rd_ok_q;
  logic [SOCK_W-1:0] rd_sock_q;
  logic [IDX_W-1:0]  idx_snap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_q   <= 1'b0;
      rd_idx_q   <= 1'b0;
      rd_ok_q    <= 1'b0;
      rd_sock_q  <= '0;
      idx_snap_q <= '0;
    end else begin
      rvalid_q <= rd_acc;
      if (rd_acc) begin
        rd_idx_q   <= (host_addr == AP_INDEX);
        rd_ok_q    <= sel_active;
        rd_sock_q  <= sock_sel;
        idx_snap_q <= idx_q;
      end
    end
  end

  always_comb begin
    if (rd_idx_q)     host_rdata = DATA_W'(idx_snap_q);
    else if (rd_ok_q) host_rdata = bank_rd[rd_sock_q];
    else              host_rdata = '0;
  end

  assign host_rvalid  = rvalid_q;
  assign sock_count   = count_q;
  assign card_present = bank_present & active_q;
endmodule

// File: rtl/sockreg_checker.sv
module sockreg_checker #(
  parameter int NUM_SOCK = 4,
  parameter int DATA_W   = 8,
  parameter int CNT_W    = $clog2(NUM_SOCK + 1)
) (
  input logic                clk,
  input logic                rst,
  input logic                host_addr,
  input logic                host_wr,
  input logic                host_rd,
  input logic [DATA_W-1:0]   host_wdata,
  input logic [DATA_W-1:0]   host_rdata,
  input logic                host_rvalid,
  input logic [1:0]          cfg_strap,
  input logic [CNT_W-1:0]    sock_count,
  input logic [NUM_SOCK-1:0] card_present
);
  logic [DATA_W-1:0] idx_m, idx_at_rd;
  logic              rd_was_idx, rd_inactive;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_m <= '0; idx_at_rd <= '0; rd_was_idx <= 1'b0; rd_inactive <= 1'b0;
    end else begin
      if (host_wr && !host_addr) idx_m <= host_wdata;
      if (host_rd && !host_wr) begin
        idx_at_rd   <= idx_m;
        rd_was_idx  <= !host_addr;
        rd_inactive <= ({1'b0, idx_m[7:6]} >= sock_count);
      end
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!host_rvalid && card_present == '0)); // R1
  AST_INDEX_READBACK: assert property (@(posedge clk) disable iff (rst)
    (host_rvalid && rd_was_idx) |-> host_rdata == idx_at_rd); // R2
  AST_RVALID_AFTER_RD: assert property (@(posedge clk) disable iff (rst)
    (host_rd && !host_wr) |=> host_rvalid); // R3
  AST_NO_SPURIOUS_RVALID: assert property (@(posedge clk) disable iff (rst)
    !(host_rd && !host_wr) |=> !host_rvalid); // R10
  AST_COUNT_FROM_STRAP: assert property (@(posedge clk) disable iff (rst)
    (cfg_strap == 2'b01) |=> sock_count == 3'd1); // R5
  AST_INACTIVE_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (host_rvalid && !rd_was_idx && rd_inactive) |-> host_rdata == '0); // R6
  AST_PRESENT_ACTIVE_ONLY: assert property (@(posedge clk) disable iff (rst)
    (card_present >> sock_count) == '0); // R8
endmodule

bind sockreg_front sockreg_checker #(.NUM_SOCK(NUM_SOCK), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_sockreg_front.sv
`timescale 1ns/1ps
module sim_sockreg_front;
  logic       clk = 1'b0, rst = 1'b1;
  logic       host_addr = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = '0, host_rdata;
  logic       host_rvalid;
  logic [1:0] cfg_strap = 2'b10;
  logic [2:0] sock_count;
  logic [3:0] card_present;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  sockreg_front u0 (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); host_addr = a; host_wr = 1'b1; host_wdata = d;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic rd(input logic a, input logic [7:0] exp, input string tag);
    @(negedge clk); host_addr = a; host_rd = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); host_rd = 1'b0;
  endtask

  task automatic put(input logic [7:0] idx, input logic [7:0] d);
    wr(1'b0, idx); wr(1'b1, d);
  endtask

  task automatic get(input logic [7:0] idx, input logic [7:0] exp, input string tag);
    wr(1'b0, idx); rd(1'b1, exp, tag);
  endtask

  task automatic set_strap(input logic [1:0] s);
    @(negedge clk); cfg_strap = s; @(negedge clk);
  endtask

  // monitor: compare each returned byte with the oldest expectation
  always @(negedge clk) begin
    if (!rst && host_rvalid) begin
      if (exp_q.size() == 0) check(1'b0, "R10 unexpected read data", host_rdata, 0);
      else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(host_rdata === e, t, host_rdata, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    check(sock_count == 3'd4, "R5 strap 10", sock_count, 4);
    check(card_present == 4'h0, "R1 present after reset", card_present, 0);
    check(host_rvalid == 1'b0, "R1 rvalid after reset", host_rvalid, 0);
    rd(1'b0, 8'h00, "R1 index reset");
    get(8'h41, 8'h00, "R1 register reset");
    wr(1'b0, 8'h05); rd(1'b0, 8'h05, "R2 index readback");
    wr(1'b1, 8'h5A); rd(1'b1, 8'h5A, "R3 data window");
    put(8'h45, 8'hC3); put(8'h85, 8'h11); put(8'hC5, 8'h22);
    get(8'h05, 8'h5A, "R4 socket0"); get(8'h45, 8'hC3, "R4 socket1");
    get(8'h85, 8'h11, "R4 socket2"); get(8'hC5, 8'h22, "R4 socket3");
    put(8'h10, 8'h34); put(8'h11, 8'h12);
    get(8'h10, 8'h34, "R7 low byte"); get(8'h11, 8'h12, "R7 high byte");
    put(8'h1F, 8'h01); put(8'h20, 8'hF0); put(8'h21, 8'h02);
    get(8'h20, 8'hF0, "R9 read phase");
    put(8'h20, 8'hF1);
    get(8'h1F, 8'h01, "R9 lower neighbour"); get(8'h20, 8'hF1, "R9 target");
    get(8'h21, 8'h02, "R9 upper neighbour");
    put(8'h81, 8'h0C); check(card_present == 4'b0100, "R8 bits 3:2 set", card_present, 4'b0100);
    put(8'h81, 8'h08); check(card_present == 4'b0000, "R8 bit2 clear", card_present, 0);
    put(8'h01, 8'h0F); check(card_present == 4'b0001, "R8 socket0", card_present, 1);
    put(8'hC1, 8'h0C); check(card_present == 4'b1001, "R8 socket3", card_present, 9);
    set_strap(2'b00);
    check(sock_count == 3'd2, "R5 strap 00", sock_count, 2);
    check(card_present == 4'b0001, "R8 masked by count", card_present, 1);
    set_strap(2'b01);
    check(sock_count == 3'd1, "R5 strap 01", sock_count, 1);
    put(8'h46, 8'h77);
    get(8'h46, 8'h00, "R6 inactive read");
    get(8'h45, 8'h00, "R6 inactive existing");
    set_strap(2'b11);
    check(sock_count == 3'd4, "R5 strap 11", sock_count, 4);
    get(8'h46, 8'h00, "R6 write was ignored");
    get(8'h45, 8'hC3, "R6 data kept");
    wr(1'b0, 8'h30);
    @(negedge clk); host_addr = 1'b1; host_rd = 1'b1; host_wr = 1'b1; host_wdata = 8'h99;
    @(negedge clk); host_rd = 1'b0; host_wr = 1'b0;
    @(negedge clk);
    rd(1'b1, 8'h99, "R10 write wins");
    @(negedge clk); rst = 1'b1; repeat (2) @(negedge clk); rst = 1'b0;
    check(card_present == 4'h0, "R1 present after mid reset", card_present, 0);
    rd(1'b0, 8'h00, "R1 index after mid reset");
    get(8'h05, 8'h00, "R1 register after mid reset");
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R3 all reads answered", exp_q.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule